// File: doc/BRIEF.md
# Masked GPIO Port Register Bank

This block is the register bank of one 16-pin general-purpose I/O port. A single output latch drives the pins. Software reaches that latch through three write views, all at their own offsets:

- a pin-value register that writes both levels;
- a set register that only raises bits;
- a clear register that only lowers bits.

Narrow accesses to the pin-value register use the byte strobes. Byte lane 0 covers pins 0–7, byte lane 1 at the next byte address covers pins 8–15, and a half-word access with both low strobes covers all sixteen pins.

A per-pin mask register gates the set, clear and pin-value accesses. Its bits are active low: a mask bit of 0 opens the pin to the access. Each pin also has a direction bit and a function-select bit. A pin drives its output enable only when it is in GPIO mode and set as an output. Reads of the pin-value register return the external pin levels after a two-flop synchroniser. Reads of the set register return the latch itself.

The bus is a single-cycle register interface. Address, write enable, four byte strobes and write data are sampled on the rising clock edge. Read data is a combinational function of the address and the current register state.

Each access is routed by an address decoder that names one register select:

- `SEL_DIR`: direction, offset 0x00.
- `SEL_FUNC`: function select, offset 0x04.
- `SEL_MASK`: mask, offset 0x08.
- `SEL_PIN`: pin value, offset 0x0C.
- `SEL_SET`: set, offset 0x10.
- `SEL_CLR`: clear, offset 0x14.
- `SEL_NONE`: any other offset.

There are no sequential states. The select is recomputed every cycle from the address.

Top module: `gpio_bank`

## Requirements
- R1: After reset the direction, function-select, mask and output-latch registers are all 0, so `pin_out` and `pin_oe` are 0.
- R2: `pin_oe[i]` is 1 exactly when direction bit i is 1 (output) and function-select bit i is 0 (GPIO).
- R3: A write to the pin-value register (0x0C) loads each strobed, unmasked latch bit with the written bit, 0 or 1. Latch bits whose mask bit is 1 keep their value.
- R4: Byte strobe 0 covers pins 0–7 from data bits 7:0, and byte strobe 1 covers pins 8–15 from data bits 15:8. Strobes 2 and 3 (bits 31:16, reserved) change nothing.
- R5: A write to the set register (0x10) makes a latch bit 1 where the data bit is 1, the bit is strobed and its mask bit is 0. Data bits of 0 leave the latch unchanged.
- R6: A set or clear write leaves unchanged every pin that is an input (direction 0) or assigned to its alternate function (function-select 1).
- R7: A write to the clear register (0x14) makes a latch bit 0 where the data bit is 1, the bit is strobed and its mask bit is 0, under the same gating as R5 and R6.
- R8: A read of the set register returns the output latch, whatever the external pin levels.
- R9: A read of the pin-value register returns `pin_in` as sampled two rising edges earlier, with masked pins (mask 1) read as 0 and bits 31:16 read as 0.
- R10: `pin_out` always equals the output latch, and the latch changes only in the cycle after a pin-value, set or clear write.
- R11: The direction (0x00), function-select (0x04) and mask (0x08) registers read back in bits 15:0 the values last written through the strobed lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 6 | Byte address of the register, word aligned |
| bus_wr | input | 1 | Write enable |
| bus_be | input | 4 | Byte strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| pin_in | input | 16 | External pin levels |
| pin_out | output | 16 | Output latch to the pads |
| pin_oe | output | 16 | Per-pin output enable |

## Verification
The hardest case to reach from the ports is a set or clear write that spans pins in every gating condition at once. Within one write, some pins are masked, some are inputs, some are in alternate function and some are open. Every bit of the result has to match its own rule.

The stimulus first builds a latch pattern through masked pin-value writes. It then arranges the direction and function-select registers so that one wide set or clear write covers all four cases, and checks the resulting latch bit by bit on `pin_out`.

The synchroniser latency is also checked. The bench changes `pin_in` between edges and reads the pin-value register after one edge and again after two.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int unsigned BUS_W  = 32;
    localparam int unsigned LANE_W = 8;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DIR,
        SEL_FUNC,
        SEL_MASK,
        SEL_PIN,
        SEL_SET,
        SEL_CLR
    } reg_sel_e;

endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
    import gpio_bank_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    localparam logic [IDX_W-1:0] IDX_DIR  = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_FUNC = IDX_W'(1);
    localparam logic [IDX_W-1:0] IDX_MASK = IDX_W'(2);
    localparam logic [IDX_W-1:0] IDX_PIN  = IDX_W'(3);
    localparam logic [IDX_W-1:0] IDX_SET  = IDX_W'(4);
    localparam logic [IDX_W-1:0] IDX_CLR  = IDX_W'(5);

    logic [IDX_W-1:0] word_idx;
    logic [1:0]       unused_byte_ofs;

    assign word_idx        = addr[ADDR_W-1:2];
    assign unused_byte_ofs = addr[1:0];

    always_comb begin
        unique case (word_idx)
            IDX_DIR:  sel = SEL_DIR;
            IDX_FUNC: sel = SEL_FUNC;
            IDX_MASK: sel = SEL_MASK;
            IDX_PIN:  sel = SEL_PIN;
            IDX_SET:  sel = SEL_SET;
            IDX_CLR:  sel = SEL_CLR;
            default:  sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [1:0] settle_q;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic meta_q;
        logic hold_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                hold_q <= 1'b0;
            end else begin
                meta_q <= async_in[b];
                hold_q <= meta_q;
            end
        end

        assign sync_out[b] = hold_q;
    end

    // Counts edges since reset so the latency check only looks at
    // history that exists.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settle_q <= 2'd0;
        end else if (settle_q != 2'd2) begin
            settle_q <= settle_q + 2'd1;
        end
    end

    p_two_stage_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_q == 2'd2) |-> (sync_out == $past(async_in, 2)));

endmodule

// File: rtl/gpio_bank_latch.sv
module gpio_bank_latch #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_wr,
    input  logic             set_wr,
    input  logic             clr_wr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] lane_en,
    input  logic [WIDTH-1:0] mask,
    input  logic [WIDTH-1:0] gpio_out,
    output logic [WIDTH-1:0] latch_q
);
    logic [WIDTH-1:0] open_bits;
    logic [WIDTH-1:0] drive_bits;
    logic [WIDTH-1:0] latch_d;

    // Active-low mask: a 0 opens the pin to the access.
    assign open_bits  = lane_en & ~mask;
    assign drive_bits = open_bits & gpio_out & wdata;

    always_comb begin
        latch_d = latch_q;
        if (pin_wr) begin
            latch_d = (latch_q & ~open_bits) | (wdata & open_bits);
        end else if (set_wr) begin
            latch_d = latch_q | drive_bits;
        end else if (clr_wr) begin
            latch_d = latch_q & ~drive_bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else begin
            latch_q <= latch_d;
        end
    end

    p_mask_protects_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((latch_q ^ $past(latch_q)) & $past(mask)) == '0);

    p_set_never_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(set_wr) |-> (($past(latch_q) & ~latch_q) == '0));

    p_set_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(set_wr) |-> ((latch_q & ~$past(latch_q) & ~$past(gpio_out)) == '0));

    p_clr_never_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_wr) |-> ((latch_q & ~$past(latch_q)) == '0));

    p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pin_wr || set_wr || clr_wr) |-> $stable(latch_q));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned PINS   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe
);
    localparam int unsigned LANES  = PINS / LANE_W;
    localparam int unsigned SPARE  = BUS_W - PINS;
    localparam int unsigned SPARE_BE = 4 - LANES;

    reg_sel_e         sel;
    logic [PINS-1:0]  lane_en;
    logic [PINS-1:0]  wdata_pins;
    logic [PINS-1:0]  dir_q;
    logic [PINS-1:0]  func_q;
    logic [PINS-1:0]  mask_q;
    logic [PINS-1:0]  latch_q;
    logic [PINS-1:0]  pin_sync;
    logic [PINS-1:0]  gpio_out;
    logic [PINS-1:0]  rd_pins;
    logic [SPARE-1:0] unused_wdata_hi;
    logic [SPARE_BE-1:0] unused_be_hi;

    assign wdata_pins      = bus_wdata[PINS-1:0];
    assign unused_wdata_hi = bus_wdata[BUS_W-1:PINS];
    assign unused_be_hi    = bus_be[3:LANES];

    gpio_bank_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    // Configuration registers, one generate slice per byte lane.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_en[l*LANE_W +: LANE_W] = {LANE_W{bus_be[l]}};

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dir_q[l*LANE_W +: LANE_W]  <= '0;
                func_q[l*LANE_W +: LANE_W] <= '0;
                mask_q[l*LANE_W +: LANE_W] <= '0;
            end else if (bus_wr && bus_be[l]) begin
                unique case (sel)
                    SEL_DIR:  dir_q[l*LANE_W +: LANE_W]  <= wdata_pins[l*LANE_W +: LANE_W];
                    SEL_FUNC: func_q[l*LANE_W +: LANE_W] <= wdata_pins[l*LANE_W +: LANE_W];
                    SEL_MASK: mask_q[l*LANE_W +: LANE_W] <= wdata_pins[l*LANE_W +: LANE_W];
                    default:  ;
                endcase
            end
        end
    end

    assign gpio_out = dir_q & ~func_q;

    gpio_bank_latch #(.WIDTH(PINS)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_wr   (bus_wr && (sel == SEL_PIN)),
        .set_wr   (bus_wr && (sel == SEL_SET)),
        .clr_wr   (bus_wr && (sel == SEL_CLR)),
        .wdata    (wdata_pins),
        .lane_en  (lane_en),
        .mask     (mask_q),
        .gpio_out (gpio_out),
        .latch_q  (latch_q)
    );

    gpio_bank_sync #(.WIDTH(PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    always_comb begin
        unique case (sel)
            SEL_DIR:  rd_pins = dir_q;
            SEL_FUNC: rd_pins = func_q;
            SEL_MASK: rd_pins = mask_q;
            SEL_PIN:  rd_pins = pin_sync & ~mask_q;
            SEL_SET:  rd_pins = latch_q;
            default:  rd_pins = '0;
        endcase
    end

    assign bus_rdata = {{SPARE{1'b0}}, rd_pins};
    assign pin_out   = latch_q;
    assign pin_oe    = gpio_out;

    p_oe_needs_output_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~dir_q) == '0);

    p_oe_needs_gpio_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & func_q) == '0);

    p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_PIN) |-> (bus_rdata[31:16] == 16'h0));

    p_masked_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_PIN) |-> ((bus_rdata[PINS-1:0] & mask_q) == '0));

endmodule

// File: tb/gpio_bank_test.sv
module gpio_bank_test;

    localparam int CLK_PERIOD = 10;

    localparam logic [5:0] A_DIR  = 6'h00;
    localparam logic [5:0] A_FUNC = 6'h04;
    localparam logic [5:0] A_MASK = 6'h08;
    localparam logic [5:0] A_PIN  = 6'h0C;
    localparam logic [5:0] A_SET  = 6'h10;
    localparam logic [5:0] A_CLR  = 6'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    gpio_bank uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_be    = be;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_be    = '0;
        #1;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 pin_out", {16'h0, pin_out}, 32'h0);
        check("R1 pin_oe", {16'h0, pin_oe}, 32'h0);
        bus_read(A_DIR, d);  check("R1 dir", d, 32'h0);
        bus_read(A_MASK, d); check("R1 mask", d, 32'h0);
        bus_read(A_SET, d);  check("R1 latch", d, 32'h0);
    endtask

    task automatic t_config();
        logic [31:0] d;
        bus_write(A_DIR, 4'b0011, 32'h0000_FFFF);
        bus_write(A_FUNC, 4'b0011, 32'h0000_00F0);
        bus_read(A_DIR, d);  check("R11 dir readback", d, 32'h0000_FFFF);
        bus_read(A_FUNC, d); check("R11 func readback", d, 32'h0000_00F0);
        check("R2 oe gpio output", {16'h0, pin_oe}, 32'h0000_FF0F);
    endtask

    task automatic t_pin_write();
        logic [31:0] d;
        bus_write(A_PIN, 4'b0011, 32'h0000_A5C3);
        check("R3 pin write", {16'h0, pin_out}, 32'h0000_A5C3);
        bus_read(A_SET, d); check("R10 latch equals pin_out", d, {16'h0, pin_out});
        bus_write(A_MASK, 4'b0011, 32'h0000_00FF);
        bus_write(A_PIN, 4'b0011, 32'h0000_0000);
        check("R3 masked pins hold", {16'h0, pin_out}, 32'h0000_00C3);
    endtask

    task automatic t_lanes();
        bus_write(A_MASK, 4'b0011, 32'h0);
        bus_write(A_PIN, 4'b0010, 32'h0000_7E00);
        check("R4 upper byte lane", {16'h0, pin_out}, 32'h0000_7EC3);
        bus_write(A_PIN, 4'b0001, 32'h0000_0011);
        check("R4 lower byte lane", {16'h0, pin_out}, 32'h0000_7E11);
        bus_write(A_PIN, 4'b1100, 32'hFFFF_FFFF);
        check("R4 reserved lanes ignored", {16'h0, pin_out}, 32'h0000_7E11);
    endtask

    task automatic t_set_clear();
        bus_write(A_SET, 4'b0011, 32'h0000_FFFF);
        check("R6 set skips alt pins", {16'h0, pin_out}, 32'h0000_FF1F);
        bus_write(A_DIR, 4'b0011, 32'h0000_00FF);
        check("R2 oe after dir change", {16'h0, pin_oe}, 32'h0000_000F);
        bus_write(A_CLR, 4'b0011, 32'h0000_FFFF);
        check("R7 clear gated", {16'h0, pin_out}, 32'h0000_FF10);
        bus_write(A_SET, 4'b0011, 32'h0000_FF00);
        check("R6 set skips inputs", {16'h0, pin_out}, 32'h0000_FF10);
    endtask

    task automatic t_set_mask();
        bus_write(A_DIR, 4'b0011, 32'h0000_FFFF);
        bus_write(A_FUNC, 4'b0011, 32'h0);
        bus_write(A_MASK, 4'b0011, 32'h0000_0001);
        bus_write(A_CLR, 4'b0011, 32'h0000_FFFF);
        check("R7 clear all open", {16'h0, pin_out}, 32'h0000_0000);
        bus_write(A_SET, 4'b0011, 32'h0000_0001);
        check("R5 set masked pin", {16'h0, pin_out}, 32'h0000_0000);
        bus_write(A_SET, 4'b0011, 32'h0000_0002);
        check("R5 set open pin", {16'h0, pin_out}, 32'h0000_0002);
        bus_write(A_SET, 4'b0011, 32'h0000_0000);
        check("R5 zero write no effect", {16'h0, pin_out}, 32'h0000_0002);
    endtask

    task automatic t_readback();
        logic [31:0] d;
        @(negedge clk);
        pin_in = 16'hFFFF;
        repeat (3) @(negedge clk);
        bus_read(A_SET, d); check("R8 set read is latch", d, 32'h0000_0002);
        bus_read(A_PIN, d); check("R9 pin read masked", d, 32'h0000_FFFE);
        @(negedge clk);
        pin_in = 16'h1234;
        @(negedge clk);
        bus_read(A_PIN, d); check("R9 one edge still old", d, 32'h0000_FFFE);
        @(negedge clk);
        bus_read(A_PIN, d); check("R9 two edges new", d, 32'h0000_1234);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_config();
        t_pin_write();
        t_lanes();
        t_set_clear();
        t_set_mask();
        t_readback();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule